// File: doc/BRIEF.md
# Dual-Channel Drive Interrupt Front End

This block sits between two disk-drive channels and a host byte bus on an expansion card. Each channel brings in a raw interrupt line from its drive. That line goes through a two-flop synchronizer. It is then gated by an enable latch that belongs to the channel. The gated lines from all channels are ORed into one interrupt request line to the host.

Software does not move data bits to change an enable latch. It uses the side effects of bus accesses. A byte write of any value to a channel's control offset arms that channel. A byte read of the same offset disarms it. Software can read a status offset for each channel to see whether that channel's drive is asserting its interrupt, whether or not the channel is enabled. A channel with no drive attached can stay disarmed for good, so its floating input never reaches the host.

The channel count, the address width and the offsets are parameters. The default configuration is two channels with control offsets 0x2200 and 0x3200 and status offsets 0x2290 and 0x3290. Each further channel adds 0x1000 to both offsets.

Top module: `ide_irq_gate`

## Requirements
- R1: After reset every channel's enable latch is 0, and `irq_o` is 0 whatever the raw inputs are.
- R2: A byte write with any data value to the control offset of channel k (default 0x2200 + k·0x1000) sets that channel's enable in the following cycle.
- R3: A byte read of the control offset of channel k clears that channel's enable in the following cycle and returns 0x00 on `rdata_o`.
- R4: A byte read of the status offset of channel k (default 0x2290 + k·0x1000) returns, in the same cycle, bit 0 equal to that channel's synchronized raw interrupt and bits 7:1 equal to 0. The result does not depend on the enable.
- R5: A raw interrupt input reaches the synchronized value, and therefore the status bit and `irq_o`, two clock edges after it changes.
- R6: `irq_o` is the OR over all channels of (enable AND synchronized raw interrupt). It is registered and updates one edge after the synchronized value or the enable changes.
- R7: A read of any unmapped offset returns 0x00 and does not change any enable. A write to an unmapped offset or to a status offset does not change any enable.
- R8: An access to one channel's offsets does not change the enable of any other channel.
- R9: `pend_o` is the OR of the synchronized raw interrupts of all channels, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (16) | Byte address of the bus access |
| rd_i | input | 1 | Byte read strobe, one cycle per access |
| wr_i | input | 1 | Byte write strobe, one cycle per access |
| wdata_i | input | 8 | Write data (its value is ignored) |
| rdata_o | output | 8 | Read data, combinational while `rd_i` is high |
| raw_irq_i | input | N_CH (2) | Raw interrupt line from each drive, asynchronous |
| irq_o | output | 1 | Registered combined interrupt request |
| pend_o | output | 1 | Card-level pending indication (OR of status bits) |

## Verification
The bench builds the block with its defaults: two channels, a 16-bit address and the standard offsets. It sweeps every combination of enable state (all four) and raw input pattern (all four), and each time predicts `irq_o` and the status reads from the formula. It also sweeps a set of write data values and a block of unmapped and near-miss addresses around each offset. With only two channels, the whole space of enable and input state can be covered exhaustively, and cross-channel interference is checked in every combination.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
   localparam int unsigned DATA_W = 8;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CTRL = 2'd1,
      HIT_STAT = 2'd2
   } hit_kind_e;

   function automatic logic [31:0] ch_offset(input logic [31:0] base,
                                             input logic [31:0] stride,
                                             input int unsigned idx);
      return base + stride * idx;
   endfunction
endpackage

// File: rtl/ide_irq_sync.sv
module ide_irq_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      if (STAGES < 2) $error("ide_irq_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("ide_irq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[0] <= '0;
               else         stage_q[0] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[s] <= '0;
               else         stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ide_irq_decode.sv
module ide_irq_decode
   import ide_irq_pkg::*;
#(
   parameter int unsigned N_CH      = 2,
   parameter int unsigned ADDR_W    = 16,
   parameter logic [31:0] CTRL_BASE = 32'h2200,
   parameter logic [31:0] STAT_BASE = 32'h2290,
   parameter logic [31:0] CH_STRIDE = 32'h1000
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [N_CH-1:0]   ctrl_hit_o,
   output logic [N_CH-1:0]   stat_hit_o
);
   initial begin
      if (N_CH < 1) $error("ide_irq_decode: N_CH must be at least 1");
      if (ADDR_W > 32 || ADDR_W < 1) $error("ide_irq_decode: ADDR_W out of range");
      if (CTRL_BASE == STAT_BASE) $error("ide_irq_decode: control and status overlap");
      if (64'(ch_offset(CTRL_BASE, CH_STRIDE, N_CH-1)) >= (64'd1 << ADDR_W))
         $error("ide_irq_decode: offsets exceed address space");
   end

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_ch
         localparam logic [31:0] CTRL_OFF = ch_offset(CTRL_BASE, CH_STRIDE, c);
         localparam logic [31:0] STAT_OFF = ch_offset(STAT_BASE, CH_STRIDE, c);
         assign ctrl_hit_o[c] = (addr_i == CTRL_OFF[ADDR_W-1:0]);
         assign stat_hit_o[c] = (addr_i == STAT_OFF[ADDR_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/ide_irq_channel.sv
module ide_irq_channel (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ctrl_hit_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic sync_irq_i,
   output logic en_o,
   output logic gated_o
);
   logic en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  en_q <= 1'b0;
      else if (ctrl_hit_i && rd_i)  en_q <= 1'b0;
      else if (ctrl_hit_i && wr_i)  en_q <= 1'b1;
   end

   assign en_o    = en_q;
   assign gated_o = en_q & sync_irq_i;

   AST_RD_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_hit_i && rd_i) |=> !en_q); // R3
   AST_WR_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_hit_i && wr_i && !rd_i) |=> en_q); // R2
   AST_EN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_hit_i |=> $stable(en_q)); // R7
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
   import ide_irq_pkg::*;
#(
   parameter int unsigned N_CH      = 2,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SYNC_STG  = 2,
   parameter logic [31:0] CTRL_BASE = 32'h2200,
   parameter logic [31:0] STAT_BASE = 32'h2290,
   parameter logic [31:0] CH_STRIDE = 32'h1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic [N_CH-1:0]   raw_irq_i,
   output logic              irq_o,
   output logic              pend_o
);
   localparam int unsigned RD_W = DATA_W;

   initial begin
      if (N_CH > 16) $error("ide_irq_gate: N_CH above 16 not supported");
   end

   logic [N_CH-1:0] ctrl_hit, stat_hit, sync_irq, en, gated;
   logic            irq_q;
   logic [RD_W-1:0] rd_mux;
   logic            unused_wdata;

   assign unused_wdata = ^wdata_i;

   ide_irq_sync #(.WIDTH(N_CH), .STAGES(SYNC_STG)) i_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw_irq_i), .q_o(sync_irq));

   ide_irq_decode #(
      .N_CH(N_CH), .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE),
      .STAT_BASE(STAT_BASE), .CH_STRIDE(CH_STRIDE)
   ) i_dec (
      .addr_i(addr_i), .ctrl_hit_o(ctrl_hit), .stat_hit_o(stat_hit));

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_ch
         ide_irq_channel i_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ctrl_hit_i(ctrl_hit[c]),
            .rd_i      (rd_i),
            .wr_i      (wr_i),
            .sync_irq_i(sync_irq[c]),
            .en_o      (en[c]),
            .gated_o   (gated[c]));
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (rd_i) begin
         for (int k = 0; k < N_CH; k++) begin
            if (stat_hit[k]) rd_mux[0] = sync_irq[k];
         end
      end
   end
   assign rdata_o = rd_mux;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |gated;
   end
   assign irq_o  = irq_q;
   assign pend_o = |sync_irq;

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> $past(|(en & sync_irq))); // R6
   AST_NO_IRQ_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en == '0) |=> !irq_q); // R1
   AST_RDATA_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[7:1] == '0); // R4
   AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_i || stat_hit == '0) |-> rdata_o == '0); // R7
   AST_PEND_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_o |-> (sync_irq != '0)); // R9
endmodule

// File: tb/test_ide_irq_gate.sv
`timescale 1ns/1ps
module test_ide_irq_gate;
   localparam int N = 2;
   logic clk = 0, rst_n = 0;
   logic [15:0] addr = '0;
   logic rd = 0, wr = 0;
   logic [7:0] wdata = '0, rdata;
   logic [N-1:0] raw = '0;
   logic irq, pend;
   int checks = 0, fails = 0;
   logic [N-1:0] en_m = '0;
   logic done = 0;

   always #2 clk = ~clk;

   ide_irq_gate i_ide_irq_gate (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
      .wdata_i(wdata), .rdata_o(rdata), .raw_irq_i(raw), .irq_o(irq), .pend_o(pend));

   function automatic logic [15:0] ctl(int k); return 16'h2200 + 16'(k) * 16'h1000; endfunction
   function automatic logic [15:0] sta(int k); return 16'h2290 + 16'(k) * 16'h1000; endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1;
      @(negedge clk); wr = 0; addr = 16'h0000;
   endtask

   // read one byte; data sampled before the edge that applies side effects
   task automatic bus_rd(logic [15:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1;
      #1 d = rdata;
      @(negedge clk); rd = 0; addr = 16'h0000;
   endtask

   task automatic set_raw(logic [N-1:0] v);
      @(negedge clk); raw = v;
      repeat (3) @(negedge clk);  // 2 sync edges + 1 irq register edge
   endtask

   task automatic set_en(logic [N-1:0] v);
      logic [7:0] d;
      for (int k = 0; k < N; k++) begin
         if (v[k]) bus_wr(ctl(k), 8'h5A);
         else bus_rd(ctl(k), d);
      end
      en_m = v;
      @(negedge clk);
   endtask

   task automatic check_state(string req);
      logic [7:0] d;
      chk(req, {7'b0, irq}, {7'b0, |(en_m & raw)});
      chk("R9", {7'b0, pend}, {7'b0, |raw});
      for (int k = 0; k < N; k++) begin
         bus_rd(sta(k), d);
         chk("R4", d, {7'b0, raw[k]});
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      raw = 2'b11;
      repeat (3) @(negedge clk);
      chk("R1", {7'b0, irq}, 8'h0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk("R1", {7'b0, irq}, 8'h0);   // raw active but disabled after reset
      chk("R9", {7'b0, pend}, 8'h1);

      // R5: latency of two edges through the synchronizer
      raw = 2'b00; repeat (3) @(negedge clk);
      @(negedge clk); raw = 2'b01;
      @(negedge clk); chk("R5", {7'b0, pend}, 8'h0);
      @(negedge clk); chk("R5", {7'b0, pend}, 8'h1);

      // exhaustive sweep of enable x raw: R2, R3, R6, R8
      for (int e = 0; e < 4; e++) begin
         for (int r = 0; r < 4; r++) begin
            set_en(2'(e));
            set_raw(2'(r));
            check_state("R6");
         end
      end

      // R2: any write value arms; R3: control read returns 0 and disarms
      set_raw(2'b01);
      for (int v = 0; v < 256; v += 51) begin
         bus_rd(ctl(0), d);
         chk("R3", d, 8'h00);
         @(negedge clk);
         chk("R3", {7'b0, irq}, 8'h0);
         bus_wr(ctl(0), 8'(v));
         @(negedge clk);
         chk("R2", {7'b0, irq}, 8'h1);
      end
      en_m = 2'b01;

      // R8: channel 1 access leaves channel 0 enabled
      bus_rd(ctl(1), d);
      @(negedge clk);
      chk("R8", {7'b0, irq}, 8'h1);

      // R7: unmapped reads/writes and status writes leave enables alone
      for (int k = 0; k < N; k++) begin
         for (int o = -2; o <= 2; o++) begin
            if (o == 0) continue;
            bus_rd(ctl(k) + 16'(o), d); chk("R7", d, 8'h00);
            bus_rd(sta(k) + 16'(o), d); chk("R7", d, 8'h00);
         end
      end
      bus_rd(16'h0000, d); chk("R7", d, 8'h00);
      bus_rd(16'hFFFF, d); chk("R7", d, 8'h00);
      @(negedge clk);
      chk("R7", {7'b0, irq}, 8'h1);      // ch0 still armed
      set_raw(2'b10);
      bus_wr(sta(1), 8'hFF);
      bus_wr(ctl(1) + 16'd4, 8'hFF);
      bus_wr(16'h1234, 8'hFF);
      @(negedge clk);
      chk("R7", {7'b0, irq}, 8'h0);      // ch1 still disarmed

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule